// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block is the watchdog inside a clock generator's control logic. Software programs it through a small two-address register port. It holds a 5-bit timeout count, a unit select, an enable, a sticky timeout flag, and two switches that decide when a system reset pulse is sent. The watchdog does not run freely. With the enable set, it arms only when a frequency change is accepted. It then counts down in units of base ticks. A `tick_in` strobe supplies the base time, so the long real-time intervals shrink to a few clock cycles in simulation.

On expiry the block does three things:
- It sets the sticky flag.
- It can send a reset pulse of fixed length.
- It forces the output frequency selection to a recovery value and locks it.

While locked, every frequency-change request is dropped. The only way to release the lock is to write the enable bit to 0.

Top module: `wdt_recovery_ctrl`

## Requirements
- R1: After reset:
  - Address 0 reads 0x1F: timeout field in bits 4:0 is 31, unit select in bit 5 is 0.
  - Address 1 reads 0x00: bit 0 enable, bit 1 timeout flag, bit 2 reset-on-timeout, bit 3 reset-on-change.
  - `sys_rst` and `locked` are 0, and `freq_sel` equals BOOT_SEL.
- R2: A `freq_req` sampled while unlocked loads `freq_req_sel` into `freq_sel` at the next clock edge.
- R3: With enable at 1, no countdown happens until a frequency change is accepted. The watchdog is never armed while enable is 0.
- R4: Once armed, the timeout expires on the N-th tick after arming, with N = (field+1) × SHORT_TICKS when bit 5 is 0 and N = (field+1) × LONG_TICKS when bit 5 is 1.
- R5: On expiry:
  - The timeout flag (address 1, bit 1) becomes 1.
  - `locked` becomes 1.
  - `freq_sel` becomes RECOVERY_SEL.
- R6: On expiry, `sys_rst` goes high for exactly RST_CYCLES cycles if bit 2 is set, and stays low otherwise.
- R7: When bit 3 is set, every accepted frequency change produces a `sys_rst` pulse of RST_CYCLES cycles, with or without a timeout.
- R8: Writing 1 to bit 1 of address 1 clears the timeout flag. Writing 0 there leaves it unchanged.
- R9: While `locked` is 1, frequency requests leave `freq_sel` unchanged.
- R10: Writing enable (address 1, bit 0) to 0 clears `locked` and disarms the countdown.
- R11: If an expiry and a frequency request fall in the same cycle, the expiry wins. `freq_sel` takes RECOVERY_SEL and the block locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle base time strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 timeout config, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| freq_req | input | 1 | Frequency change request |
| freq_req_sel | input | FSEL_W | Requested frequency selection |
| freq_sel | output | FSEL_W | Active frequency selection |
| sys_rst | output | 1 | System reset pulse |
| locked | output | 1 | Recovery lock active |

## Verification
The assertions assume that `tick_in` is a single-cycle strobe and that `reg_addr` is only 0 or 1. They also assume that the register and request inputs are held stable around each rising edge.

The bench meets these assumptions in three ways:
- All inputs are driven on the falling edge from one stepping task.
- Ticks alternate on every other step.
- A write and a request never share a cycle except where a rule needs them together.

The same-cycle expiry-versus-request case is placed deliberately: the bench waits until the count shows one tick left and the next step carries a tick.

// File: rtl/wdt_recovery_ctrl.sv
module wdt_recovery_ctrl #(
  parameter int FSEL_W = 4,
  parameter logic [FSEL_W-1:0] BOOT_SEL = '0,
  parameter logic [FSEL_W-1:0] RECOVERY_SEL = 4'h5,
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              freq_req,
  input  logic [FSEL_W-1:0] freq_req_sel,
  output logic [FSEL_W-1:0] freq_sel,
  output logic              sys_rst,
  output logic              locked
);
  localparam int CNT_W = $clog2(32 * LONG_TICKS + 1);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [4:0]       tmo_field;
  logic             pre_long;
  logic             en, status, rst_on_to, rst_on_fc;
  logic             armed;
  logic [CNT_W-1:0] remain;
  logic [RST_W-1:0] rst_left;

  wire wr_cfg     = reg_we && !reg_addr;
  wire wr_ctl     = reg_we && reg_addr;
  wire disable_wr = wr_ctl && !reg_wdata[0];

  wire [CNT_W-1:0] unit_len = pre_long ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
  wire [CNT_W-1:0] load_val = CNT_W'(tmo_field + 6'd1) * unit_len;

  wire expire_hit = armed && tick_in && (remain == CNT_W'(1)) && !disable_wr;
  wire fc_accept  = freq_req && !locked && !expire_hit;
  wire rst_fire   = (expire_hit && rst_on_to) || (fc_accept && rst_on_fc);

  assign reg_rdata = reg_addr ? {4'b0, rst_on_fc, rst_on_to, status, en}
                              : {2'b0, pre_long, tmo_field};
  assign sys_rst   = (rst_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_field <= 5'h1F;
      pre_long  <= 1'b0;
      en        <= 1'b0;
      rst_on_to <= 1'b0;
      rst_on_fc <= 1'b0;
    end else begin
      if (wr_cfg) begin
        tmo_field <= reg_wdata[4:0];
        pre_long  <= reg_wdata[5];
      end
      if (wr_ctl) begin
        en        <= reg_wdata[0];
        rst_on_to <= reg_wdata[2];
        rst_on_fc <= reg_wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      status <= 1'b0;
    else if (expire_hit)             status <= 1'b1;
    else if (wr_ctl && reg_wdata[1]) status <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      locked <= 1'b0;
      remain <= '0;
    end else if (disable_wr) begin
      armed  <= 1'b0;
      locked <= 1'b0;
      remain <= load_val;
    end else if (expire_hit) begin
      armed  <= 1'b0;
      locked <= 1'b1;
    end else if (fc_accept && en) begin
      armed  <= 1'b1;
      remain <= load_val;
    end else if (armed && tick_in) begin
      remain <= remain - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          freq_sel <= BOOT_SEL;
    else if (expire_hit) freq_sel <= RECOVERY_SEL;
    else if (fc_accept)  freq_sel <= freq_req_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rst_left <= '0;
    else if (rst_fire)         rst_left <= RST_W'(RST_CYCLES);
    else if (rst_left != '0)   rst_left <= rst_left - RST_W'(1);
  end
endmodule

// File: rtl/wdt_recovery_ctrl_chk.sv
module wdt_recovery_ctrl_chk #(
  parameter int FSEL_W = 4,
  parameter logic [FSEL_W-1:0] RECOVERY_SEL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              freq_req,
  input logic [FSEL_W-1:0] freq_sel,
  input logic              sys_rst,
  input logic              en,
  input logic              status,
  input logic              armed,
  input logic              expire_hit,
  input logic              fc_accept,
  input logic              rst_on_to,
  input logic              rst_on_fc
);
  p_locked_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && freq_req) |=> (freq_sel == $past(freq_sel)));

  p_lock_loads_recovery_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (freq_sel == RECOVERY_SEL && status));

  p_unlock_needs_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !en);

  p_armed_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> en);

  // R6 and R7: a reset pulse starts only from a timeout or an accepted change
  p_rst_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past((expire_hit && rst_on_to) || (fc_accept && rst_on_fc)));

  p_expiry_beats_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_hit && freq_req) |=> (locked && freq_sel == RECOVERY_SEL));
endmodule

bind wdt_recovery_ctrl wdt_recovery_ctrl_chk #(.FSEL_W(FSEL_W), .RECOVERY_SEL(RECOVERY_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .freq_req(freq_req), .freq_sel(freq_sel),
  .sys_rst(sys_rst), .en(en), .status(status), .armed(armed), .expire_hit(expire_hit),
  .fc_accept(fc_accept), .rst_on_to(rst_on_to), .rst_on_fc(rst_on_fc)
);

// File: tb/tb_wdt_recovery_ctrl.sv
`timescale 1ns/1ps
module tb_wdt_recovery_ctrl;
  localparam int SHORT = 3, LONG = 8, RSTC = 4;
  localparam logic [3:0] BOOT = 4'h0, RECOV = 4'h5;

  logic clk = 0, rst_n = 0;
  logic tick_in = 0, reg_we = 0, reg_addr = 0, freq_req = 0;
  logic [7:0] reg_wdata = 0;
  logic [3:0] freq_req_sel = 0;
  logic [7:0] reg_rdata;
  logic [3:0] freq_sel;
  logic sys_rst, locked;

  int checks = 0, fails = 0;
  bit tphase = 0, tick_on = 0, done = 0;
  logic view_addr = 0;

  always #4 clk = ~clk;

  wdt_recovery_ctrl #(.FSEL_W(4), .BOOT_SEL(BOOT), .RECOVERY_SEL(RECOV),
    .SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .freq_req(freq_req),
    .freq_req_sel(freq_req_sel), .freq_sel(freq_sel), .sys_rst(sys_rst), .locked(locked));

  // behavioural reference
  int m_field, m_remain, m_rleft;
  bit m_pre, m_en, m_status, m_rto, m_rfc, m_armed, m_locked;
  logic [3:0] m_sel;

  always @(posedge clk or negedge rst_n) begin
    int load;
    bit dis, expv, acc, arm;
    if (!rst_n) begin
      m_field = 31; m_pre = 0; m_en = 0; m_status = 0; m_rto = 0; m_rfc = 0;
      m_armed = 0; m_locked = 0; m_remain = 0; m_rleft = 0; m_sel = BOOT;
    end else begin
      load = (m_field + 1) * (m_pre ? LONG : SHORT);
      dis  = reg_we && reg_addr && !reg_wdata[0];
      expv = m_armed && tick_in && m_remain == 1 && !dis;
      acc  = freq_req && !m_locked && !expv;
      arm  = acc && m_en && !dis;
      if ((expv && m_rto) || (acc && m_rfc)) m_rleft = RSTC;
      else if (m_rleft > 0) m_rleft--;
      if (expv) m_sel = RECOV; else if (acc) m_sel = freq_req_sel;
      if (expv) m_status = 1; else if (reg_we && reg_addr && reg_wdata[1]) m_status = 0;
      if (dis) begin m_armed = 0; m_locked = 0; m_remain = load; end
      else if (expv) begin m_armed = 0; m_locked = 1; end
      else if (arm) begin m_armed = 1; m_remain = load; end
      else if (m_armed && tick_in) m_remain--;
      if (reg_we && !reg_addr) begin m_field = reg_wdata[4:0]; m_pre = reg_wdata[5]; end
      if (reg_we && reg_addr) begin m_en = reg_wdata[0]; m_rto = reg_wdata[2]; m_rfc = reg_wdata[3]; end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] mr;
    #2;
    if (rst_n && !done) begin
      mr = reg_addr ? {4'b0, m_rfc, m_rto, m_status, m_en} : {2'b0, m_pre, 5'(m_field)};
      check("R2 freq_sel vs model", freq_sel, m_sel);
      check("R6 sys_rst vs model", sys_rst, m_rleft != 0);
      check("R5 locked vs model", locked, m_locked);
      check("R8 rdata vs model", reg_rdata, mr);
    end
  end

  task automatic cyc(input logic we, input logic a, input logic [7:0] d,
                     input logic rq, input logic [3:0] s);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; freq_req = rq; freq_req_sel = s;
    tick_in = tick_on && tphase;
    tphase = ~tphase;
  endtask
  task automatic wr(input logic a, input logic [7:0] d); cyc(1, a, d, 0, 4'h0); endtask
  task automatic req(input logic [3:0] s); cyc(0, view_addr, 8'h0, 1, s); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, view_addr, 8'h0, 0, 4'h0);
  endtask
  task automatic settle; @(posedge clk); #2; endtask

  // count ticks until lock; returns ticks and whether sys_rst rose with lock
  task automatic measure(output int ticks, output bit rst_at_lock);
    ticks = 0; rst_at_lock = 0;
    settle();
    for (int i = 0; i < 2000; i++) begin
      idle(1);
      @(posedge clk);
      if (tick_in) ticks++;
      #2;
      if (locked) begin rst_at_lock = sys_rst; break; end
    end
  endtask

  task automatic pulse_width(output int w);
    w = sys_rst ? 1 : 0;
    for (int i = 0; i < 20; i++) begin
      idle(1); settle();
      if (sys_rst) w++;
    end
  endtask

  initial begin
    int t, w;
    bit r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    check("R1 cfg default", reg_rdata, 8'h1F);
    check("R1 freq_sel default", freq_sel, BOOT);
    check("R1 sys_rst default", sys_rst, 0);
    check("R1 locked default", locked, 0);
    view_addr = 1; idle(1); settle();
    check("R1 ctl default", reg_rdata, 8'h00);
    tick_on = 1;

    req(4'h3); settle();
    check("R2 request accepted", freq_sel, 4'h3);
    idle(200);
    check("R3 disabled never locks", locked, 0);

    wr(0, 8'h02);             // field 2, short unit -> 9 ticks
    wr(1, 8'h05);             // enable + reset on timeout
    idle(60);
    check("R3 no arm before change", locked, 0);
    req(4'h7);
    measure(t, r);
    check("R4 short timeout ticks", t, 3 * SHORT);
    check("R5 locked on expiry", locked, 1);
    check("R5 recovery selection", freq_sel, RECOV);
    check("R6 reset at expiry", r, 1);
    pulse_width(w);
    check("R6 pulse width", w, RSTC);
    view_addr = 1; idle(1); settle();
    check("R5 status set", reg_rdata[1], 1);

    req(4'h3); settle();
    check("R9 locked ignores request", freq_sel, RECOV);
    wr(1, 8'h05); settle();
    check("R8 write 0 keeps status", reg_rdata[1], 1);
    wr(1, 8'h07); settle();
    check("R8 write 1 clears status", reg_rdata[1], 0);
    check("R10 lock kept while enabled", locked, 1);
    wr(1, 8'h00); settle();
    check("R10 disable releases lock", locked, 0);
    req(4'h9); settle();
    check("R10 request accepted after release", freq_sel, 4'h9);

    wr(0, 8'h20);             // field 0, long unit -> 8 ticks
    wr(1, 8'h01);             // enable, no reset on timeout
    req(4'h2);
    measure(t, r);
    check("R4 long timeout ticks", t, LONG);
    check("R6 no reset when bit clear", r, 0);
    pulse_width(w);
    check("R6 no pulse after expiry", w, 0);

    wr(1, 8'h08); settle();    // disable, reset on change
    check("R10 release again", locked, 0);
    req(4'hA); settle();
    check("R7 reset on change", sys_rst, 1);
    pulse_width(w);
    check("R7 pulse width", w, RSTC);

    wr(0, 8'h00);             // 3 ticks
    wr(1, 8'h01);
    req(4'h4); settle();
    for (int i = 0; i < 100; i++) begin
      if (m_armed && m_remain == 1 && tphase) break;
      idle(1); settle();
    end
    req(4'hC); settle();
    check("R11 expiry wins lock", locked, 1);
    check("R11 expiry wins selection", freq_sel, RECOV);
    idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired (actual=hang expected=finish)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule